// File: doc/BRIEF.md
# Reconfigurable Region Freeze Sequencer with Isolating Bridge

This block guards one partially reconfigurable region. Host software drives a small register port to walk the region through a freeze and restart handshake. On a start command the block raises a freeze request and waits for the region to acknowledge it. It then holds the region in reset and reports that the region is ready to be rewritten. A completion command releases the reset and raises a restart request. The region's acknowledgement of that request returns the block to its idle state. A programmable cycle limit flags a missing acknowledgement in either waiting state.

The block also sits in the region's memory-mapped slave path. In idle, host accesses pass straight through to the region, with a parameterised cap on outstanding pipelined reads. From the moment a freeze is requested until the restart is acknowledged, the bridge answers host accesses itself. Reads return a fixed marker word with an error response. Writes are discarded. Reads already issued to the region are drained and returned in order before any local answer is given, and the region is declared frozen only once they are drained. Each reconfigurable region gets its own instance of this block.

Top module: `pr_freeze_ctrl`

## Requirements
- R1: After reset the status register reads 0 (state idle, no error), freeze request, restart request and region reset are low, and the timeout limit register (offset 2) reads the parameter default.
- R2: Writing a 1 to control bit 0 (offset 0) in idle moves the state to 1 (freeze requested) and raises the freeze request at the same clock edge. Bit 0 is ignored in every other state.
- R3: From state 1 the block enters state 2 (frozen) only when the freeze acknowledge is high and no region read is outstanding. While frozen the region reset output is high and the freeze request stays high.
- R4: Writing a 1 to control bit 1 in state 2 moves the state to 3 (restart requested): the freeze request and region reset drop and the restart request rises. A high restart acknowledge then returns the state to 0. Bit 1 is ignored in other states, and the two requests are never high together.
- R5: The status register (offset 1) holds the state code in bits 1:0 and a sticky timeout error in bit 8. The error is set when the limit-register value of consecutive clock edges pass in state 1 or 3 without the awaited acknowledge. A limit of 0 disables the check. Writing a 1 to control bit 2 clears the error.
- R6: In idle, host reads and writes are forwarded to the region unchanged, and read data returns in order with response code 0.
- R7: From state 1 through state 3, a host read with no region read outstanding is accepted at once and answered one cycle later with data 0xDEADBEEF and response code 2. The region sees no read.
- R8: From state 1 through state 3, host writes are accepted with waitrequest low and never reach the region.
- R9: Reads already issued to the region when a freeze starts return their region data, in order, before any locally answered read. Host waitrequest is held only until they drain.
- R10: No more than MAX_OUT reads are outstanding at the region. Further reads see waitrequest until a response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 2 | Register word offset |
| csr_write | input | 1 | Register write strobe |
| csr_writedata | input | 32 | Register write data |
| csr_read | input | 1 | Register read strobe |
| csr_readdata | output | 32 | Register read data, one cycle after the strobe |
| csr_rvalid | output | 1 | Register read data valid |
| frz_req | output | 1 | Freeze request to the region |
| frz_ack | input | 1 | Freeze acknowledge from the region |
| start_req | output | 1 | Restart request to the region |
| start_ack | input | 1 | Restart acknowledge from the region |
| region_reset | output | 1 | Region held in reset while frozen |
| h_addr | input | AW | Host slave address |
| h_read | input | 1 | Host read |
| h_write | input | 1 | Host write |
| h_wdata | input | DW | Host write data |
| h_waitreq | output | 1 | Host waitrequest |
| h_rdata | output | DW | Host read data |
| h_rvalid | output | 1 | Host read data valid |
| h_resp | output | 2 | Host response (0 ok, 2 error) |
| r_addr | output | AW | Region address |
| r_read | output | 1 | Region read |
| r_write | output | 1 | Region write |
| r_wdata | output | DW | Region write data |
| r_waitreq | input | 1 | Region waitrequest |
| r_rdata | input | DW | Region read data |
| r_rvalid | input | 1 | Region read data valid |

## Verification
The two functions that can meet in one cycle are the return of a region read response that was issued before the freeze and the local answer to a host read arriving during the freeze. The bench provokes this by issuing a pipelined read to a slow region model, starting the freeze on the next cycle with the freeze acknowledge already high, and presenting a new read at once. A scoreboard judges the result. The region's data must come back first with response 0, and the marker word with response 2 must follow. The region reset must still be low when the region data returns, and the host must have seen waitrequest while the drain was pending.

// File: rtl/prfz_pkg.sv
package prfz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_FRZ_REQ   = 2'd1,
    ST_FROZEN    = 2'd2,
    ST_START_REQ = 2'd3
  } frz_state_e;

  localparam logic [31:0] FILL_WORD   = 32'hDEAD_BEEF;
  localparam logic [1:0]  RESP_OK     = 2'b00;
  localparam logic [1:0]  RESP_SLVERR = 2'b10;

  localparam logic [1:0]  REG_CTRL    = 2'd0;
  localparam logic [1:0]  REG_STATUS  = 2'd1;
  localparam logic [1:0]  REG_LIMIT   = 2'd2;

  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_DONE_BIT  = 1;
  localparam int CTRL_CLR_BIT   = 2;
  localparam int STAT_ERR_BIT   = 8;

endpackage

// File: rtl/prfz_csr.sv
module prfz_csr
  import prfz_pkg::*;
#(
  parameter int TO_W   = 32,
  parameter int TO_DEF = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      csr_addr,
  input  logic            csr_write,
  input  logic [31:0]     csr_writedata,
  input  logic            csr_read,
  output logic [31:0]     csr_readdata,
  output logic            csr_rvalid,
  input  frz_state_e      state,
  input  logic            err,
  output logic            cmd_start,
  output logic            cmd_done,
  output logic            cmd_clr,
  output logic [TO_W-1:0] to_limit
);

  logic ctrl_wr;
  logic [31:0] status_word;

  assign ctrl_wr   = csr_write && (csr_addr == REG_CTRL);
  assign cmd_start = ctrl_wr && csr_writedata[CTRL_START_BIT];
  assign cmd_done  = ctrl_wr && csr_writedata[CTRL_DONE_BIT];
  assign cmd_clr   = ctrl_wr && csr_writedata[CTRL_CLR_BIT];

  always_comb begin
    status_word = '0;
    status_word[1:0] = state;
    status_word[STAT_ERR_BIT] = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      to_limit <= TO_W'(TO_DEF);
    end else if (csr_write && (csr_addr == REG_LIMIT)) begin
      to_limit <= csr_writedata[TO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rvalid   <= 1'b0;
      csr_readdata <= '0;
    end else begin
      csr_rvalid <= csr_read;
      if (csr_read) begin
        case (csr_addr)
          REG_STATUS: csr_readdata <= status_word;
          REG_LIMIT:  csr_readdata <= 32'(to_limit);
          default:    csr_readdata <= '0;
        endcase
      end
    end
  end

  // R5: a read strobe is always answered on the following cycle
  p_read_answered_r5: assert property (@(posedge clk) disable iff (rst)
    csr_read |=> csr_rvalid);

endmodule

// File: rtl/prfz_seq.sv
module prfz_seq
  import prfz_pkg::*;
#(
  parameter int TO_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_start,
  input  logic            cmd_done,
  input  logic            cmd_clr,
  input  logic [TO_W-1:0] to_limit,
  input  logic            frz_ack,
  input  logic            start_ack,
  input  logic            drained,
  output frz_state_e      state,
  output logic            err,
  output logic            frz_req,
  output logic            start_req,
  output logic            region_reset,
  output logic            block
);

  frz_state_e nxt;
  logic [TO_W-1:0] timer;
  logic waiting;
  logic expired;

  assign waiting = (state == ST_FRZ_REQ) || (state == ST_START_REQ);
  assign expired = waiting && (nxt == state) && (to_limit != '0) &&
                   (timer == to_limit - TO_W'(1));

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:      if (cmd_start)            nxt = ST_FRZ_REQ;
      ST_FRZ_REQ:   if (frz_ack && drained)   nxt = ST_FROZEN;
      ST_FROZEN:    if (cmd_done)             nxt = ST_START_REQ;
      ST_START_REQ: if (start_ack)            nxt = ST_IDLE;
      default:                                nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      frz_req      <= 1'b0;
      start_req    <= 1'b0;
      region_reset <= 1'b0;
      block        <= 1'b0;
    end else begin
      state        <= nxt;
      frz_req      <= (nxt == ST_FRZ_REQ) || (nxt == ST_FROZEN);
      start_req    <= (nxt == ST_START_REQ);
      region_reset <= (nxt == ST_FROZEN);
      block        <= (nxt != ST_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
    end else if (nxt != state) begin
      timer <= '0;
    end else if (waiting && (timer != '1)) begin
      timer <= timer + TO_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else if (expired) begin
      err <= 1'b1;
    end else if (cmd_clr) begin
      err <= 1'b0;
    end
  end

  // R4: the two handshake requests are mutually exclusive
  p_req_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(frz_req && start_req));

  // R4: frozen is left only towards the restart request
  p_frozen_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FROZEN) |=> (state == ST_FROZEN) || (state == ST_START_REQ));

  // R3: the region is never frozen with a read still owed by it
  p_frozen_drained_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FROZEN) |-> drained);

  // R5: the timeout error holds until cleared
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (err && !cmd_clr) |=> err);

endmodule

// File: rtl/prfz_bridge.sv
module prfz_bridge
  import prfz_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          block,
  output logic          drained,
  input  logic [AW-1:0] h_addr,
  input  logic          h_read,
  input  logic          h_write,
  input  logic [DW-1:0] h_wdata,
  output logic          h_waitreq,
  output logic [DW-1:0] h_rdata,
  output logic          h_rvalid,
  output logic [1:0]    h_resp,
  output logic [AW-1:0] r_addr,
  output logic          r_read,
  output logic          r_write,
  output logic [DW-1:0] r_wdata,
  input  logic          r_waitreq,
  input  logic [DW-1:0] r_rdata,
  input  logic          r_rvalid
);

  localparam int CW = $clog2(MAX_OUT + 1);

  logic [CW-1:0] pend;
  logic room;
  logic pass_acc;
  logic loc_rd;

  assign room     = (pend < CW'(MAX_OUT));
  assign drained  = (pend == '0);
  assign r_addr   = h_addr;
  assign r_wdata  = h_wdata;
  assign r_read   = h_read && !block && room;
  assign r_write  = h_write && !block;
  assign pass_acc = r_read && !r_waitreq;
  assign loc_rd   = block && h_read && drained;

  always_comb begin
    if (block) begin
      h_waitreq = !drained;
    end else begin
      h_waitreq = r_waitreq || (h_read && !room);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
    end else begin
      case ({pass_acc, r_rvalid})
        2'b10:   pend <= pend + CW'(1);
        2'b01:   pend <= pend - CW'(1);
        default: pend <= pend;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      h_resp   <= RESP_OK;
    end else begin
      h_rvalid <= r_rvalid || loc_rd;
      if (r_rvalid) begin
        h_rdata <= r_rdata;
        h_resp  <= RESP_OK;
      end else if (loc_rd) begin
        h_rdata <= DW'(FILL_WORD);
        h_resp  <= RESP_SLVERR;
      end
    end
  end

  // R10: outstanding region reads never exceed the cap
  p_pend_bound_r10: assert property (@(posedge clk) disable iff (rst)
    pend <= CW'(MAX_OUT));

  // R9: a region response always belongs to an issued read
  p_resp_owned_r9: assert property (@(posedge clk) disable iff (rst)
    r_rvalid |-> !drained);

  // R9: a local answer never coincides with a region response
  p_no_collision_r9: assert property (@(posedge clk) disable iff (rst)
    !(r_rvalid && loc_rd));

  // R7: a local read is answered with the error code on the next cycle
  p_local_resp_r7: assert property (@(posedge clk) disable iff (rst)
    loc_rd |=> h_rvalid && (h_resp == RESP_SLVERR));

endmodule

// File: rtl/pr_freeze_ctrl.sv
module pr_freeze_ctrl
  import prfz_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int MAX_OUT = 4,
  parameter int TO_W    = 32,
  parameter int TO_DEF  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    csr_addr,
  input  logic          csr_write,
  input  logic [31:0]   csr_writedata,
  input  logic          csr_read,
  output logic [31:0]   csr_readdata,
  output logic          csr_rvalid,
  output logic          frz_req,
  input  logic          frz_ack,
  output logic          start_req,
  input  logic          start_ack,
  output logic          region_reset,
  input  logic [AW-1:0] h_addr,
  input  logic          h_read,
  input  logic          h_write,
  input  logic [DW-1:0] h_wdata,
  output logic          h_waitreq,
  output logic [DW-1:0] h_rdata,
  output logic          h_rvalid,
  output logic [1:0]    h_resp,
  output logic [AW-1:0] r_addr,
  output logic          r_read,
  output logic          r_write,
  output logic [DW-1:0] r_wdata,
  input  logic          r_waitreq,
  input  logic [DW-1:0] r_rdata,
  input  logic          r_rvalid
);

  frz_state_e      state;
  logic            err;
  logic            cmd_start;
  logic            cmd_done;
  logic            cmd_clr;
  logic [TO_W-1:0] to_limit;
  logic            drained;
  logic            block;

  prfz_csr #(.TO_W(TO_W), .TO_DEF(TO_DEF)) u_csr (
    .clk           (clk),
    .rst           (rst),
    .csr_addr      (csr_addr),
    .csr_write     (csr_write),
    .csr_writedata (csr_writedata),
    .csr_read      (csr_read),
    .csr_readdata  (csr_readdata),
    .csr_rvalid    (csr_rvalid),
    .state         (state),
    .err           (err),
    .cmd_start     (cmd_start),
    .cmd_done      (cmd_done),
    .cmd_clr       (cmd_clr),
    .to_limit      (to_limit)
  );

  prfz_seq #(.TO_W(TO_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_start    (cmd_start),
    .cmd_done     (cmd_done),
    .cmd_clr      (cmd_clr),
    .to_limit     (to_limit),
    .frz_ack      (frz_ack),
    .start_ack    (start_ack),
    .drained      (drained),
    .state        (state),
    .err          (err),
    .frz_req      (frz_req),
    .start_req    (start_req),
    .region_reset (region_reset),
    .block        (block)
  );

  prfz_bridge #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT)) u_bridge (
    .clk       (clk),
    .rst       (rst),
    .block     (block),
    .drained   (drained),
    .h_addr    (h_addr),
    .h_read    (h_read),
    .h_write   (h_write),
    .h_wdata   (h_wdata),
    .h_waitreq (h_waitreq),
    .h_rdata   (h_rdata),
    .h_rvalid  (h_rvalid),
    .h_resp    (h_resp),
    .r_addr    (r_addr),
    .r_read    (r_read),
    .r_write   (r_write),
    .r_wdata   (r_wdata),
    .r_waitreq (r_waitreq),
    .r_rdata   (r_rdata),
    .r_rvalid  (r_rvalid)
  );

  // R8: while the region is isolated no write reaches it
  p_no_write_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !r_write);

  // R3: region reset is only asserted together with the freeze request
  p_reset_with_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    region_reset |-> frz_req);

endmodule

// File: tb/tb_pr_freeze_ctrl.sv
module tb_pr_freeze_ctrl;

  localparam int AW      = 12;
  localparam int DW      = 32;
  localparam int MAX_OUT = 4;
  localparam int LAT     = 4;
  localparam int TO_DEF  = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst;
  logic [1:0]    csr_addr;
  logic          csr_write;
  logic [31:0]   csr_writedata;
  logic          csr_read;
  logic [31:0]   csr_readdata;
  logic          csr_rvalid;
  logic          frz_req, frz_ack, start_req, start_ack, region_reset;
  logic [AW-1:0] h_addr;
  logic          h_read, h_write;
  logic [DW-1:0] h_wdata;
  logic          h_waitreq;
  logic [DW-1:0] h_rdata;
  logic          h_rvalid;
  logic [1:0]    h_resp;
  logic [AW-1:0] r_addr;
  logic          r_read, r_write;
  logic [DW-1:0] r_wdata;
  logic          r_waitreq;
  logic [DW-1:0] r_rdata;
  logic          r_rvalid;

  pr_freeze_ctrl #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT), .TO_W(32), .TO_DEF(TO_DEF)) dut (
    .clk(clk), .rst(rst),
    .csr_addr(csr_addr), .csr_write(csr_write), .csr_writedata(csr_writedata),
    .csr_read(csr_read), .csr_readdata(csr_readdata), .csr_rvalid(csr_rvalid),
    .frz_req(frz_req), .frz_ack(frz_ack), .start_req(start_req), .start_ack(start_ack),
    .region_reset(region_reset),
    .h_addr(h_addr), .h_read(h_read), .h_write(h_write), .h_wdata(h_wdata),
    .h_waitreq(h_waitreq), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_resp(h_resp),
    .r_addr(r_addr), .r_read(r_read), .r_write(r_write), .r_wdata(r_wdata),
    .r_waitreq(r_waitreq), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] region_word(input logic [AW-1:0] a);
    return {20'hC0DE0, a};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // region model: fixed-latency pipelined slave, never stalls
  logic [LAT-1:0] rv;
  logic [AW-1:0]  ra [LAT];
  int rd_cnt = 0;
  int wr_cnt = 0;
  logic [DW-1:0] last_wd;
  assign r_waitreq = 1'b0;
  assign r_rvalid  = rv[LAT-1];
  assign r_rdata   = region_word(ra[LAT-1]);

  always @(posedge clk) begin
    if (rst) begin
      rv <= '0;
    end else begin
      rv <= {rv[LAT-2:0], r_read};
      ra[0] <= r_addr;
      for (int k = 1; k < LAT; k++) ra[k] <= ra[k-1];
      if (r_read) rd_cnt <= rd_cnt + 1;
      if (r_write) begin
        wr_cnt  <= wr_cnt + 1;
        last_wd <= r_wdata;
      end
    end
  end

  int max_occ = 0;
  always @(negedge clk) if (!rst && ($countones(rv) > max_occ)) max_occ = $countones(rv);

  // scoreboard
  logic [33:0] sb_q[$];
  bit bench_block = 1'b0;
  bit watch_reset = 1'b0;

  always @(negedge clk) begin
    if (!rst && h_rvalid) begin
      if (sb_q.size() == 0) begin
        check("R6", "unexpected read response", {30'd0, h_resp}, 32'hFFFF_FFFF);
      end else begin
        logic [33:0] e;
        e = sb_q.pop_front();
        check(e[33:32] == 2'b10 ? "R7" : "R6", "read data", h_rdata, e[31:0]);
        check(e[33:32] == 2'b10 ? "R7" : "R6", "read response", {30'd0, h_resp}, {30'd0, e[33:32]});
        if (watch_reset && e[33:32] == 2'b00)
          check("R9", "region reset low at drained response", {31'd0, region_reset}, 32'd0);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    csr_addr = a; csr_writedata = d; csr_write = 1'b1;
    @(negedge clk);
    csr_write = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    csr_addr = a; csr_read = 1'b1;
    @(negedge clk);
    csr_read = 1'b0;
    d = csr_readdata;
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output int waits);
    h_addr = a; h_read = 1'b1; waits = 0;
    forever begin
      #1;
      if (!h_waitreq) begin
        if (bench_block) sb_q.push_back({2'b10, 32'hDEAD_BEEF});
        else             sb_q.push_back({2'b00, region_word(a)});
        @(negedge clk);
        break;
      end
      waits++;
      @(negedge clk);
    end
  endtask

  task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
    h_addr = a; h_wdata = d; h_write = 1'b1; waits = 0;
    forever begin
      #1;
      if (!h_waitreq) begin
        @(negedge clk);
        break;
      end
      waits++;
      @(negedge clk);
    end
    h_write = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w;
    int tot_w;
    int rc;
    int wc;
    rst = 1'b1;
    csr_addr = '0; csr_write = 1'b0; csr_writedata = '0; csr_read = 1'b0;
    frz_ack = 1'b0; start_ack = 1'b0;
    h_addr = '0; h_read = 1'b0; h_write = 1'b0; h_wdata = '0;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    csr_rd(2'd1, d);
    check("R1", "status after reset", d, 32'h0);
    check("R1", "requests and reset low", {29'd0, frz_req, start_req, region_reset}, 32'd0);
    csr_rd(2'd2, d);
    check("R1", "limit default", d, TO_DEF);

    // R6 pass-through
    host_rd(12'h003, w);
    host_rd(12'h7A5, w);
    h_read = 1'b0;
    host_wr(12'h055, 32'h1234_5678, w);
    tick(LAT + 3);
    check("R6", "region write count", wr_cnt, 1);
    check("R6", "region write data", last_wd, 32'h1234_5678);

    // R4 done command ignored in idle
    csr_wr(2'd0, 32'h2);
    csr_rd(2'd1, d);
    check("R4", "done ignored in idle", d, 32'h0);

    // R10 outstanding cap under back-to-back reads
    tot_w = 0;
    for (int i = 0; i < 8; i++) begin
      host_rd(AW'(12'h100 + i), w);
      tot_w += w;
    end
    h_read = 1'b0;
    tick(LAT + 4);
    check("R10", "max outstanding at region", max_occ, MAX_OUT);
    check("R10", "waitrequest seen at cap", {31'd0, (tot_w > 0)}, 32'd1);

    // R2 / R5 freeze request with timeout
    csr_wr(2'd2, 32'd5);
    csr_rd(2'd2, d);
    check("R5", "limit readback", d, 32'd5);
    csr_wr(2'd0, 32'h1);
    bench_block = 1'b1;
    check("R2", "freeze request raised", {30'd0, frz_req, start_req}, 32'h2);
    tick(8);
    csr_rd(2'd1, d);
    check("R5", "timeout flagged in freeze wait", d, 32'h101);
    csr_wr(2'd0, 32'h4);
    csr_rd(2'd1, d);
    check("R5", "error cleared", d, 32'h001);

    // R7 blocked read, R8 blocked write
    rc = rd_cnt;
    wc = wr_cnt;
    host_rd(12'h020, w);
    h_read = 1'b0;
    check("R7", "blocked read no wait", w, 0);
    host_wr(12'h021, 32'hAAAA_5555, w);
    check("R8", "blocked write no wait", w, 0);
    tick(LAT + 2);
    check("R7", "region saw no read", rd_cnt, rc);
    check("R8", "region saw no write", wr_cnt, wc);

    // R3 ack moves to frozen
    frz_ack = 1'b1;
    tick(1);
    frz_ack = 1'b0;
    csr_rd(2'd1, d);
    check("R3", "state frozen", d, 32'h002);
    check("R3", "reset and freeze held", {30'd0, region_reset, frz_req}, 32'h3);
    csr_wr(2'd0, 32'h1);
    csr_rd(2'd1, d);
    check("R2", "start ignored when frozen", d, 32'h002);

    // R4 restart
    csr_wr(2'd0, 32'h2);
    check("R4", "restart outputs", {29'd0, frz_req, start_req, region_reset}, 32'h2);
    csr_rd(2'd1, d);
    check("R4", "state restart requested", d, 32'h003);
    start_ack = 1'b1;
    tick(1);
    start_ack = 1'b0;
    bench_block = 1'b0;
    csr_rd(2'd1, d);
    check("R4", "back to idle without error", d, 32'h000);

    // R9 in-flight read drained across the freeze start
    watch_reset = 1'b1;
    host_rd(12'h009, w);
    h_read = 1'b0;
    frz_ack = 1'b1;
    csr_wr(2'd0, 32'h1);
    bench_block = 1'b1;
    host_rd(12'h00A, w);
    h_read = 1'b0;
    check("R9", "waitrequest held while draining", {31'd0, (w > 0)}, 32'd1);
    tick(3);
    frz_ack = 1'b0;
    watch_reset = 1'b0;
    check("R9", "scoreboard drained", sb_q.size(), 0);
    csr_rd(2'd1, d);
    check("R3", "frozen after drain", d, 32'h002);
    csr_wr(2'd0, 32'h2);
    start_ack = 1'b1;
    tick(1);
    start_ack = 1'b0;
    bench_block = 1'b0;
    csr_rd(2'd1, d);
    check("R4", "idle after second restart", d, 32'h000);

    tick(4);
    check("R6", "no pending expected responses", sb_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule